// File: doc/BRIEF.md
# Programmable DRAM Address Bit Remapper

This block converts between the coordinate view of a DRAM location (row, column, bank, bank group, rank, logical rank, channel) and the flat physical address seen by the rest of the system. The relation is not a fixed slicing of the address. Each of the 38 coordinate bits carries its own 6-bit position that says which of the 64 physical address bits it lands on. The forward path scatters coordinate bits into an address. The reverse path gathers coordinate bits back out of an address. Each path is a registered, single-cycle datapath with its own valid strobe.

The 38 positions are programmed through a plain write port of eight 32-bit words. Each word carries up to five 6-bit position fields. The forward path can take its coordinates from discrete inputs, or it can unpack them from a 64-bit error-log word. That word holds a burst position, the coordinate fields and a row split into a low and a high part. Error reporting uses the log path to turn a captured log entry into the address that failed. Fault injection uses the reverse path to turn a chosen address into the coordinates to match.

Top module: `dram_addr_remap`

## Requirements
- R1: While `rst_n` is low at a clock edge, all 38 positions become 0, and both valid outputs, `phys_addr_o`, `burst_o` and every coordinate output become 0 after that edge.
- R2: When `fwd_valid_i` is high at an edge, `fwd_valid_o` is high after that edge, and `phys_addr_o` has bit p set exactly when some selected coordinate bit is 1 and its programmed position equals p. The coordinate bits are row 0..17, column 0..9, bank 0..1, group 0..1, rank 0..1, logical rank 0..2 and channel.
- R3: When several coordinate bits share one position, that address bit is the OR of those bits. The forward result never has more bits set than the selected coordinates have.
- R4: When `rev_valid_i` is high at an edge, `rev_valid_o` is high after that edge, and each coordinate output bit equals `phys_addr_i` at that bit's programmed position.
- R5: Coordinate bits that share a position all return the same address bit on the reverse path.
- R6: A write with `cfg_we_i` high stores `cfg_wdata_i` in word `cfg_idx_i`. A word holds fields A=[5:0], B=[11:6], C=[17:12], D=[23:18] and E=[29:24], and bits 31:30 have no effect. The position assignment is as follows. Word 0 holds row 0-4 in A-E. Word 1 holds row 5-9 in A-E. Word 2 holds row 10-14 in A-E. Word 3 holds row 15-17 in A-C and column 0 in E. Word 4 holds column 1-5 in A-E. Word 5 holds column 6-9 in A-D and bank 0 in E. Word 6 holds bank 1 in A, group 0 in B, group 1 in C and channel in D. Word 7 holds rank 0-1 in A-B and logical rank 0-2 in C-E. A new value applies to operations launched at later edges.
- R7: With `fwd_src_log_i` high, the coordinates come from `log_word_i`. From the LSB up, the word holds burst [2:0], logical rank [5:3], rank [7:6], group [9:8], bank [11:10], column [21:12] and low row [31:22]. The upper row sits at [63:32], and row = (upper << 10) | low, truncated to 18 bits, so bits 63:40 have no effect. The channel still comes from `chan_i`.
- R8: `burst_o` is updated on every forward operation. It takes log bits [2:0] in log mode and 0 in direct mode.
- R9: When a valid input is low at an edge, the corresponding valid output is low after that edge, and that path's data outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Position word write strobe |
| cfg_idx_i | input | 3 | Position word index |
| cfg_wdata_i | input | 32 | Position word data |
| fwd_valid_i | input | 1 | Launch a forward conversion |
| fwd_src_log_i | input | 1 | 1: coordinates from log word, 0: from discrete inputs |
| row_i | input | 18 | Row coordinate |
| col_i | input | 10 | Column coordinate |
| bank_i | input | 2 | Bank coordinate |
| grp_i | input | 2 | Bank group coordinate |
| rank_i | input | 2 | Rank coordinate |
| lrank_i | input | 3 | Logical rank coordinate |
| chan_i | input | 1 | Channel (used in both source modes) |
| log_word_i | input | 64 | Packed error-log word |
| fwd_valid_o | output | 1 | Forward result valid |
| phys_addr_o | output | 64 | Forward physical address |
| burst_o | output | 3 | Burst position from the log word |
| rev_valid_i | input | 1 | Launch a reverse conversion |
| phys_addr_i | input | 64 | Address to decompose |
| rev_valid_o | output | 1 | Reverse result valid |
| row_o | output | 18 | Recovered row |
| col_o | output | 10 | Recovered column |
| bank_o | output | 2 | Recovered bank |
| grp_o | output | 2 | Recovered group |
| rank_o | output | 2 | Recovered rank |
| lrank_o | output | 3 | Recovered logical rank |
| chan_o | output | 1 | Recovered channel |

## Verification
The first pattern is the all-zero map left by reset. Every coordinate bit then lands on address bit 0, which exposes any path that ignores the programmed positions. The second pattern is a distinct identity map written with junk in bits 31:30. It tells a correct field and word layout apart from a shifted or swapped one, because each coordinate bit must reappear at its own index. The third pattern is a set of randomly programmed maps that often collide, driven with random coordinates and addresses. It separates OR-merging and shared-bit reads from overwrite behaviour. Log words carrying junk above bit 39 confirm the split-row assembly and the burst field, and idle cycles with changing inputs confirm that the outputs hold.

// File: rtl/remap_pkg.sv
`timescale 1ns/1ps
// Shared constants and coordinate layout for the DRAM address bit remapper.
// Assumes 6-bit positions, hence a 64-bit physical address.
package remap_pkg;
    localparam int POS_W    = 6;
    localparam int ADDR_W   = 1 << POS_W;
    localparam int ROW_W    = 18;
    localparam int COL_W    = 10;
    localparam int BANK_W   = 2;
    localparam int GRP_W    = 2;
    localparam int RANK_W   = 2;
    localparam int LRANK_W  = 3;
    localparam int CH_W     = 1;
    localparam int NBITS    = ROW_W + COL_W + BANK_W + GRP_W + RANK_W + LRANK_W + CH_W;
    localparam int FIELDS   = 5;
    localparam int WORD_W   = 32;
    localparam int NWORDS   = 8;
    localparam int IDX_W    = $clog2(NWORDS);
    localparam int BURST_W  = 3;
    localparam int LOG_W    = 64;
    localparam int ROWLO_W  = 10;

    // Offsets of each coordinate inside the flat coordinate vector
    localparam int COL_OFF   = ROW_W;
    localparam int BANK_OFF  = COL_OFF + COL_W;
    localparam int GRP_OFF   = BANK_OFF + BANK_W;
    localparam int RANK_OFF  = GRP_OFF + GRP_W;
    localparam int LRANK_OFF = RANK_OFF + RANK_W;
    localparam int CH_OFF    = LRANK_OFF + LRANK_W;

    // Packed coordinates; row occupies the LSBs when flattened
    typedef struct packed {
        logic [CH_W-1:0]    ch;
        logic [LRANK_W-1:0] lrank;
        logic [RANK_W-1:0]  rank;
        logic [GRP_W-1:0]   grp;
        logic [BANK_W-1:0]  bank;
        logic [COL_W-1:0]   col;
        logic [ROW_W-1:0]   row;
    } coord_t;

    // Slot (word*FIELDS + field) holding the position of coordinate bit j
    function automatic int slot_of(int j);
        if (j < COL_OFF)      return j;          // rows fill words 0-3
        else if (j < RANK_OFF) return j + 1;     // column, bank, group skip one spare field
        else if (j == CH_OFF) return 33;         // channel sits in word 6, field D
        else                  return j + 3;      // rank and logical rank fill word 7
    endfunction
endpackage

// File: rtl/remap_cfg_regs.sv
`timescale 1ns/1ps
// Position register file: eight words of five 6-bit fields.
// Bits 31:30 of each write are dropped. Fans the stored fields out
// into one flat vector of 38 positions in coordinate-bit order.
module remap_cfg_regs
    import remap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [WORD_W-1:0]      wdata_i,
    output logic [NBITS*POS_W-1:0] pos_o
);
    localparam int STORE_W = FIELDS * POS_W;

    logic [STORE_W-1:0] words_q [NWORDS];

    // Store written words; reset clears every position to 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) words_q[w] <= '0;
        end else if (we_i) begin
            words_q[idx_i] <= wdata_i[STORE_W-1:0];
        end
    end

    // Route each stored field to its coordinate bit
    for (genvar j = 0; j < NBITS; j++) begin : g_fan
        localparam int SLOT  = slot_of(j);
        localparam int WIDX  = SLOT / FIELDS;
        localparam int FIDX  = SLOT % FIELDS;
        assign pos_o[j*POS_W +: POS_W] = words_q[WIDX][FIDX*POS_W +: POS_W];
    end
endmodule

// File: rtl/remap_scatter.sv
`timescale 1ns/1ps
// Forward scatter: ORs each coordinate bit into the address bit named
// by its position. Colliding positions merge by OR. Purely combinational.
module remap_scatter
    import remap_pkg::*;
(
    input  logic [NBITS-1:0]       coord_i,
    input  logic [NBITS*POS_W-1:0] pos_i,
    output logic [ADDR_W-1:0]      addr_o
);
    // One hit vector per address bit, reduced by OR
    for (genvar k = 0; k < ADDR_W; k++) begin : g_abit
        logic [NBITS-1:0] hit;
        for (genvar j = 0; j < NBITS; j++) begin : g_src
            assign hit[j] = coord_i[j] && (pos_i[j*POS_W +: POS_W] == POS_W'(k));
        end
        assign addr_o[k] = |hit;
    end
endmodule

// File: rtl/remap_gather.sv
`timescale 1ns/1ps
// Reverse gather: each coordinate bit reads the address bit at its
// position. Shared positions read the same bit. Purely combinational.
module remap_gather
    import remap_pkg::*;
(
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [NBITS*POS_W-1:0] pos_i,
    output logic [NBITS-1:0]       coord_o
);
    // Select one address bit per coordinate bit
    for (genvar j = 0; j < NBITS; j++) begin : g_sel
        assign coord_o[j] = addr_i[pos_i[j*POS_W +: POS_W]];
    end
endmodule

// File: rtl/remap_log_unpack.sv
`timescale 1ns/1ps
// Splits a 64-bit error-log word into coordinates and a burst position.
// Row = upper part shifted by 10 OR low part, truncated to the row width.
// The log word carries no channel, so it is taken from chan_i.
module remap_log_unpack
    import remap_pkg::*;
(
    input  logic [LOG_W-1:0]   log_i,
    input  logic [CH_W-1:0]    chan_i,
    output coord_t             coord_o,
    output logic [BURST_W-1:0] burst_o
);
    localparam int LR_LSB  = BURST_W;
    localparam int RK_LSB  = LR_LSB + LRANK_W;
    localparam int GP_LSB  = RK_LSB + RANK_W;
    localparam int BK_LSB  = GP_LSB + GRP_W;
    localparam int CL_LSB  = BK_LSB + BANK_W;
    localparam int RL_LSB  = CL_LSB + COL_W;
    localparam int RH_LSB  = LOG_W / 2;
    localparam int ROWHI_W = ROW_W - ROWLO_W;

    // Field extraction and row assembly
    always_comb begin
        burst_o       = log_i[BURST_W-1:0];
        coord_o.lrank = log_i[LR_LSB +: LRANK_W];
        coord_o.rank  = log_i[RK_LSB +: RANK_W];
        coord_o.grp   = log_i[GP_LSB +: GRP_W];
        coord_o.bank  = log_i[BK_LSB +: BANK_W];
        coord_o.col   = log_i[CL_LSB +: COL_W];
        coord_o.row   = {log_i[RH_LSB +: ROWHI_W], log_i[RL_LSB +: ROWLO_W]};
        coord_o.ch    = chan_i;
    end
endmodule

// File: rtl/dram_addr_remap.sv
`timescale 1ns/1ps
// Top of the DRAM address bit remapper. Holds the position registers,
// a registered forward path (coordinates or log word -> address) and a
// registered reverse path (address -> coordinates), one cycle each.
module dram_addr_remap
    import remap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we_i,
    input  logic [2:0]           cfg_idx_i,
    input  logic [31:0]          cfg_wdata_i,
    input  logic                 fwd_valid_i,
    input  logic                 fwd_src_log_i,
    input  logic [17:0]          row_i,
    input  logic [9:0]           col_i,
    input  logic [1:0]           bank_i,
    input  logic [1:0]           grp_i,
    input  logic [1:0]           rank_i,
    input  logic [2:0]           lrank_i,
    input  logic                 chan_i,
    input  logic [63:0]          log_word_i,
    output logic                 fwd_valid_o,
    output logic [63:0]          phys_addr_o,
    output logic [2:0]           burst_o,
    input  logic                 rev_valid_i,
    input  logic [63:0]          phys_addr_i,
    output logic                 rev_valid_o,
    output logic [17:0]          row_o,
    output logic [9:0]           col_o,
    output logic [1:0]           bank_o,
    output logic [1:0]           grp_o,
    output logic [1:0]           rank_o,
    output logic [2:0]           lrank_o,
    output logic                 chan_o
);
    logic [NBITS*POS_W-1:0] pos;
    coord_t                 direct_c, log_c, sel_c, rev_c, rev_q;
    logic [BURST_W-1:0]     log_burst;
    logic [ADDR_W-1:0]      fwd_addr;
    logic                   fwd_v_q, rev_v_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [BURST_W-1:0]     burst_q;
    logic [NBITS-1:0]       rev_flat;

    remap_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .idx_i   (cfg_idx_i),
        .wdata_i (cfg_wdata_i),
        .pos_o   (pos)
    );

    remap_log_unpack u_log (
        .log_i   (log_word_i),
        .chan_i  (chan_i),
        .coord_o (log_c),
        .burst_o (log_burst)
    );

    // Gather the discrete coordinate inputs and pick the source
    always_comb begin
        direct_c = '{ch: chan_i, lrank: lrank_i, rank: rank_i, grp: grp_i,
                     bank: bank_i, col: col_i, row: row_i};
        sel_c    = fwd_src_log_i ? log_c : direct_c;
    end

    remap_scatter u_scatter (
        .coord_i (sel_c),
        .pos_i   (pos),
        .addr_o  (fwd_addr)
    );

    remap_gather u_gather (
        .addr_i  (phys_addr_i),
        .pos_i   (pos),
        .coord_o (rev_flat)
    );

    assign rev_c = coord_t'(rev_flat);

    // Forward result register; data held while no operation is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_v_q <= 1'b0;
            addr_q  <= '0;
            burst_q <= '0;
        end else begin
            fwd_v_q <= fwd_valid_i;
            if (fwd_valid_i) begin
                addr_q  <= fwd_addr;
                burst_q <= fwd_src_log_i ? log_burst : '0;
            end
        end
    end

    // Reverse result register; data held while no operation is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_v_q <= 1'b0;
            rev_q   <= '0;
        end else begin
            rev_v_q <= rev_valid_i;
            if (rev_valid_i) rev_q <= rev_c;
        end
    end

    assign fwd_valid_o = fwd_v_q;
    assign phys_addr_o = addr_q;
    assign burst_o     = burst_q;
    assign rev_valid_o = rev_v_q;
    assign row_o       = rev_q.row;
    assign col_o       = rev_q.col;
    assign bank_o      = rev_q.bank;
    assign grp_o       = rev_q.grp;
    assign rank_o      = rev_q.rank;
    assign lrank_o     = rev_q.lrank;
    assign chan_o      = rev_q.ch;
endmodule

// File: rtl/dram_addr_remap_checks.sv
`timescale 1ns/1ps
// Temporal checks on the remapper ports, bound to every instance.
module dram_addr_remap_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        fwd_valid_i,
    input logic        fwd_src_log_i,
    input logic [17:0] row_i,
    input logic [9:0]  col_i,
    input logic [1:0]  bank_i,
    input logic [1:0]  grp_i,
    input logic [1:0]  rank_i,
    input logic [2:0]  lrank_i,
    input logic        chan_i,
    input logic        fwd_valid_o,
    input logic [63:0] phys_addr_o,
    input logic [2:0]  burst_o,
    input logic        rev_valid_i,
    input logic [63:0] phys_addr_i,
    input logic        rev_valid_o,
    input logic [17:0] row_o,
    input logic [9:0]  col_o,
    input logic [1:0]  bank_o,
    input logic [1:0]  grp_o,
    input logic [1:0]  rank_o,
    input logic [2:0]  lrank_o,
    input logic        chan_o
);
    logic [37:0] din_flat;
    logic [37:0] rout_flat;
    assign din_flat  = {chan_i, lrank_i, rank_i, grp_i, bank_i, col_i, row_i};
    assign rout_flat = {chan_o, lrank_o, rank_o, grp_o, bank_o, col_o, row_o};

    a_r2_fwd_latency: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_i |=> fwd_valid_o);

    a_r4_rev_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rev_valid_i |=> rev_valid_o);

    a_r9_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid_i |=> (!fwd_valid_o && $stable(phys_addr_o) && $stable(burst_o)));

    a_r9_rev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_valid_i |=> (!rev_valid_o && $stable(rout_flat)));

    a_r3_no_extra_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_i && !fwd_src_log_i) |=>
            ($countones(phys_addr_o) <= $past($countones(din_flat))));

    a_r4_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_valid_i && phys_addr_i == 64'd0) |=> (rout_flat == 38'd0));

    a_r8_burst_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_i && !fwd_src_log_i) |=> (burst_o == 3'd0));
endmodule

bind dram_addr_remap dram_addr_remap_checks u_checks (.*);

// File: tb/dram_addr_remap_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: random maps and coordinates against bench models.
module dram_addr_remap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_idx_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic        fwd_valid_i = 1'b0;
    logic        fwd_src_log_i = 1'b0;
    logic [37:0] fc = '0;
    logic [63:0] log_word_i = '0;
    logic        fwd_valid_o;
    logic [63:0] phys_addr_o;
    logic [2:0]  burst_o;
    logic        rev_valid_i = 1'b0;
    logic [63:0] phys_addr_i = '0;
    logic        rev_valid_o;
    logic [17:0] row_o;
    logic [9:0]  col_o;
    logic [1:0]  bank_o, grp_o, rank_o;
    logic [2:0]  lrank_o;
    logic        chan_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int pos [38];

    always #4 clk = ~clk;

    dram_addr_remap dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_wdata_i(cfg_wdata_i),
        .fwd_valid_i(fwd_valid_i), .fwd_src_log_i(fwd_src_log_i),
        .row_i(fc[17:0]), .col_i(fc[27:18]), .bank_i(fc[29:28]), .grp_i(fc[31:30]),
        .rank_i(fc[33:32]), .lrank_i(fc[36:34]), .chan_i(fc[37]),
        .log_word_i(log_word_i),
        .fwd_valid_o(fwd_valid_o), .phys_addr_o(phys_addr_o), .burst_o(burst_o),
        .rev_valid_i(rev_valid_i), .phys_addr_i(phys_addr_i),
        .rev_valid_o(rev_valid_o), .row_o(row_o), .col_o(col_o), .bank_o(bank_o),
        .grp_o(grp_o), .rank_o(rank_o), .lrank_o(lrank_o), .chan_o(chan_o)
    );

    function automatic logic [37:0] rev_out();
        return {chan_o, lrank_o, rank_o, grp_o, bank_o, col_o, row_o};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Word and field of coordinate bit j, per the layout in R6
    function automatic void place(int j, output int w, output int f);
        if (j < 15)       begin w = j / 5;        f = j % 5;        end
        else if (j < 18)  begin w = 3;            f = j - 15;       end
        else if (j == 18) begin w = 3;            f = 4;            end
        else if (j < 24)  begin w = 4;            f = j - 19;       end
        else if (j < 28)  begin w = 5;            f = j - 24;       end
        else if (j == 28) begin w = 5;            f = 4;            end
        else if (j < 32)  begin w = 6;            f = j - 29;       end
        else if (j == 37) begin w = 6;            f = 3;            end
        else              begin w = 7;            f = j - 32;       end
    endfunction

    function automatic logic [31:0] pack_word(int w, logic [1:0] junk);
        logic [31:0] r;
        int ww, ff;
        r = {junk, 30'd0};
        for (int j = 0; j < 38; j++) begin
            place(j, ww, ff);
            if (ww == w) r[ff*6 +: 6] = pos[j][5:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] fwd_model(logic [37:0] c);
        logic [63:0] a = '0;
        for (int j = 0; j < 38; j++) if (c[j]) a[pos[j]] = 1'b1;
        return a;
    endfunction

    function automatic logic [37:0] rev_model(logic [63:0] a);
        logic [37:0] c;
        for (int j = 0; j < 38; j++) c[j] = a[pos[j]];
        return c;
    endfunction

    function automatic logic [37:0] log_model(logic [63:0] lw, logic ch);
        return {ch, lw[5:3], lw[7:6], lw[9:8], lw[11:10], lw[21:12], lw[39:32], lw[31:22]};
    endfunction

    task automatic cfg_write(int idx, logic [31:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_idx_i = 3'(idx); cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic program_all(logic [1:0] junk);
        for (int w = 0; w < 8; w++) cfg_write(w, pack_word(w, junk));
    endtask

    // Launch one forward and one reverse operation in the same cycle
    task automatic launch(logic src_log, logic [37:0] c, logic [63:0] lw, logic [63:0] a);
        @(negedge clk);
        fwd_valid_i = 1'b1; fwd_src_log_i = src_log; fc = c; log_word_i = lw;
        rev_valid_i = 1'b1; phys_addr_i = a;
        @(negedge clk);
        fwd_valid_i = 1'b0; rev_valid_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [37:0] c;
        logic [63:0] a, lw, held_a;
        logic [37:0] held_c;
        void'($urandom(32'h5eed_1234));
        for (int j = 0; j < 38; j++) pos[j] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 fwd_valid", 64'(fwd_valid_o), 64'd0);
        check("R1 rev_valid", 64'(rev_valid_o), 64'd0);
        check("R1 phys_addr", phys_addr_o, 64'd0);
        check("R1 coords", 64'(rev_out()), 64'd0);
        check("R1 burst", 64'(burst_o), 64'd0);
        rst_n = 1'b1;

        // R1/R3: all positions 0 after reset, so everything lands on bit 0
        c = 38'd0; c[5] = 1'b1; c[37] = 1'b1;
        launch(1'b0, c, 64'd0, 64'd1);
        check("R1 R3 zero map fwd", phys_addr_o, 64'd1);
        check("R2 fwd_valid", 64'(fwd_valid_o), 64'd1);
        check("R5 zero map rev", 64'(rev_out()), {38{1'b1}});

        // R6: identity map written with junk in bits 31:30
        for (int j = 0; j < 38; j++) pos[j] = j;
        program_all(2'b11);
        for (int t = 0; t < 8; t++) begin
            c = {$urandom(), $urandom()};
            a = {$urandom(), $urandom()};
            launch(1'b0, c, 64'd0, a);
            check("R6 identity fwd", phys_addr_o, {26'd0, c});
            check("R6 identity rev", 64'(rev_out()), 64'(a[37:0]));
        end

        // R2 R3 R4 R5: random maps (collisions likely) with random data
        for (int m = 0; m < 12; m++) begin
            for (int j = 0; j < 38; j++)
                pos[j] = (m % 3 == 0) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 63));
            program_all(2'($urandom()));
            for (int t = 0; t < 15; t++) begin
                c = {$urandom(), $urandom()};
                a = {$urandom(), $urandom()};
                launch(1'b0, c, 64'd0, a);
                check("R2 R3 fwd scatter", phys_addr_o, fwd_model(c));
                check("R4 R5 rev gather", 64'(rev_out()), 64'(rev_model(a)));
                check("R8 burst direct", 64'(burst_o), 64'd0);
            end
        end

        // R3 R5: directed collision of row bit 0 and column bit 0 at bit 7
        for (int j = 0; j < 38; j++) pos[j] = 63;
        pos[0] = 7; pos[18] = 7;
        program_all(2'b00);
        c = 38'd0; c[18] = 1'b1;
        launch(1'b0, c, 64'd0, 64'h80);
        check("R3 collision one", phys_addr_o, 64'h80);
        check("R5 collision rev", 64'(rev_out()), 64'(38'h4_0000 | 38'h1));
        c[0] = 1'b1;
        launch(1'b0, c, 64'd0, 64'h7F);
        check("R3 collision both", phys_addr_o, 64'h80);
        check("R5 collision rev zero", 64'(rev_out()), 64'd0);

        // R7 R8: log word source with junk above bit 39
        for (int j = 0; j < 38; j++) pos[j] = int'($urandom_range(0, 63));
        program_all(2'b01);
        for (int t = 0; t < 40; t++) begin
            lw = {$urandom(), $urandom()};
            c = {$urandom(), $urandom()};
            launch(1'b1, c, lw, 64'd0);
            check("R7 log fwd", phys_addr_o, fwd_model(log_model(lw, c[37])));
            check("R8 burst log", 64'(burst_o), 64'(lw[2:0]));
        end

        // R9: hold while idle, inputs changing
        launch(1'b1, {$urandom(), $urandom()}, 64'h0000_0000_FFFF_FFFD, 64'hFFFF_0000_FFFF_0000);
        held_a = phys_addr_o; held_c = rev_out();
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            fc = {$urandom(), $urandom()}; log_word_i = {$urandom(), $urandom()};
            phys_addr_i = {$urandom(), $urandom()};
        end
        @(negedge clk);
        check("R9 fwd idle valid", 64'(fwd_valid_o), 64'd0);
        check("R9 rev idle valid", 64'(rev_valid_o), 64'd0);
        check("R9 fwd hold", phys_addr_o, held_a);
        check("R9 rev hold", 64'(rev_out()), 64'(held_c));
        check("R9 burst hold", 64'(burst_o), 64'd5);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule